// File: doc/BRIEF.md
# Micro-op Dispatch Slot Controller

This block sits at the front of an out-of-order back end and decides, one clock at a time, whether the instruction at its input may be dispatched. A dispatch cycle holds a fixed number of micro-op slots (`DISP_W`). Each instruction arrives with its micro-op count and two group flags. The block also watches three downstream conditions: free reorder-buffer entries, register-file availability and next-stage readiness. It raises `accept` only when the slots and all three resources allow it. When it refuses, it drives a stall-cause code.

The boundary between dispatch cycles is marked by `cycleBegin`. When that input is high, the next clock edge opens a new dispatch cycle. An instruction with more micro-ops than the dispatch width takes every slot of its cycle. Its surplus is then drained across the following cycles. The slots used by that drain are reported on `spillUops`, and no new instruction is taken until the surplus is gone. Slot usage by accepted instructions appears on `instUops`.

Top module: `uop_dispatch_slots`

## Requirements
- R1: After a synchronous reset `slotsLeft` equals `DISP_W`, and `carryLeft` and `spillUops` are zero.
- R2: An instruction needs min(`uopCount`, `DISP_W`) slots. It is refused when that exceeds `slotsLeft`. When accepted, `slotsLeft` drops by that amount at the clock edge.
- R3: An instruction with `uopCount` > `DISP_W` is accepted only when all slots are free. It leaves `slotsLeft` at zero and `carryLeft` at `uopCount` - `DISP_W`.
- R4: A clock edge with `cycleBegin` high and no surplus pending sets `slotsLeft` to `DISP_W`.
- R5: A clock edge with `cycleBegin` high and surplus c pending consumes k = min(c, `DISP_W`). It sets `slotsLeft` to `DISP_W` - k and `carryLeft` to c - k, and `spillUops` shows k for the following clock. In all other clocks `spillUops` is zero.
- R6: While `carryLeft` is non-zero, `accept` stays low.
- R7: While `slotsLeft` is zero, `accept` stays low.
- R8: An instruction with `beginGroup` set is refused unless `slotsLeft` equals `DISP_W`.
- R9: An accepted instruction with `endGroup` set leaves `slotsLeft` at zero until the next cycle begins.
- R10: Acceptance needs `robFree` ≥ `uopCount`, `rfReady` high and `nextReady` high, all in the same clock.
- R11: `stallCode` is 0 when the instruction is accepted or when `instValid` is low. Otherwise it gives the first failing cause in this order: 1 = slot limits (R2, R3, R6, R7, R8), 2 = reorder buffer, 3 = register file, 4 = next stage.
- R12: `instUops` equals min(`uopCount`, `DISP_W`) while `accept` is high and is zero otherwise. `accept` and `instUops` are combinational in the current inputs and state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is offered this clock |
| uopCount | input | UOP_W | Micro-op count of the offered instruction (1 or more) |
| beginGroup | input | 1 | Instruction must start a dispatch cycle |
| endGroup | input | 1 | Instruction closes its dispatch cycle |
| robFree | input | ROB_W | Free reorder-buffer entries |
| rfReady | input | 1 | Register file can take the instruction |
| nextReady | input | 1 | Next stage can take the instruction |
| cycleBegin | input | 1 | This edge opens a new dispatch cycle |
| accept | output | 1 | Instruction taken this clock |
| stallCode | output | 3 | Refusal cause |
| instUops | output | CNT_W | Slots used by the accepted instruction |
| spillUops | output | CNT_W | Surplus micro-ops dispatched at the last cycle start |
| slotsLeft | output | CNT_W | Slots still free in the current cycle |
| carryLeft | output | UOP_W | Surplus micro-ops still waiting |

## Verification
The assertions assume `uopCount` is never zero while `instValid` is high. They also assume the downstream signals describe the same clock in which they are sampled. The stimulus sweeps counts from 1 to `2*DISP_W+1`. Before each instruction under test it uses a prefix instruction to reach each possible slot level, and it crosses this with both group flags and every readiness pattern. Each trial ends with idle cycle starts, which clear any surplus so the next trial starts from a full cycle.

// File: rtl/dispatch_slot_pkg.sv
`timescale 1ns/1ps
package dispatch_slot_pkg;

  typedef enum logic [2:0] {
    STALL_NONE  = 3'd0,
    STALL_SLOTS = 3'd1,
    STALL_ROB   = 3'd2,
    STALL_RF    = 3'd3,
    STALL_NEXT  = 3'd4
  } stall_e;

  typedef struct packed {
    logic take;        // instruction accepted this clock
    logic wide;        // its count exceeds the dispatch width
    logic closeGroup;  // accepted and ends its group
    logic newCycle;    // edge opens a new dispatch cycle
  } slotStrobes_t;

endpackage

// File: rtl/dispatch_slot_ctrl.sv
`timescale 1ns/1ps
module dispatch_slot_ctrl
  import dispatch_slot_pkg::*;
#(
  parameter int unsigned DISP_W = 4,
  parameter int unsigned UOP_W  = 4,
  parameter int unsigned ROB_W  = 6,
  localparam int unsigned CNT_W = $clog2(DISP_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [UOP_W-1:0] uopCount,
  input  logic             beginGroup,
  input  logic             endGroup,
  input  logic [ROB_W-1:0] robFree,
  input  logic             rfReady,
  input  logic             nextReady,
  input  logic             cycleBegin,
  input  logic [CNT_W-1:0] slotsLeft,
  input  logic [UOP_W-1:0] carryLeft,
  output logic             accept,
  output stall_e           stallCode,
  output logic [CNT_W-1:0] needSlots,
  output slotStrobes_t     strobes
);

  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(DISP_W);
  localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(DISP_W);

  logic isWide;
  logic slotBlock;
  logic robShort;

  assign isWide    = uopCount > WIDTH_U;
  assign needSlots = isWide ? WIDTH_C : CNT_W'(uopCount);
  assign robShort  = robFree < ROB_W'(uopCount);

  assign slotBlock = (carryLeft != '0)
                   || (slotsLeft == '0)
                   || (needSlots > slotsLeft)
                   || (beginGroup && (slotsLeft != WIDTH_C));

  always_comb begin
    stallCode = STALL_NONE;
    if (instValid) begin
      if (slotBlock)       stallCode = STALL_SLOTS;
      else if (robShort)   stallCode = STALL_ROB;
      else if (!rfReady)   stallCode = STALL_RF;
      else if (!nextReady) stallCode = STALL_NEXT;
    end
  end

  assign accept = instValid && (stallCode == STALL_NONE);

  always_comb begin
    strobes.take       = accept;
    strobes.wide       = isWide;
    strobes.closeGroup = accept && endGroup;
    strobes.newCycle   = cycleBegin;
  end

  // R6
  no_accept_in_spill_chk: assert property (@(posedge clk) disable iff (rst)
    (carryLeft != '0) |-> !accept);

  // R8
  begin_needs_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && beginGroup) |-> (slotsLeft == WIDTH_C));

  // R10
  resources_ready_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (rfReady && nextReady && (robFree >= ROB_W'(uopCount))));

endmodule

// File: rtl/dispatch_slot_data.sv
`timescale 1ns/1ps
module dispatch_slot_data
  import dispatch_slot_pkg::*;
#(
  parameter int unsigned DISP_W = 4,
  parameter int unsigned UOP_W  = 4,
  localparam int unsigned CNT_W = $clog2(DISP_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  slotStrobes_t     strobes,
  input  logic [CNT_W-1:0] needSlots,
  input  logic [UOP_W-1:0] uopCount,
  output logic [CNT_W-1:0] slotsLeft,
  output logic [UOP_W-1:0] carryLeft,
  output logic [CNT_W-1:0] spillUops,
  output logic [CNT_W-1:0] instUops
);

  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(DISP_W);
  localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(DISP_W);

  logic [CNT_W-1:0] availMid, availNext, consumed, spillNext;
  logic [UOP_W-1:0] carryMid, carryNext;

  assign instUops = strobes.take ? needSlots : '0;

  // Effect of this clock's accepted instruction, inside the current cycle.
  always_comb begin
    availMid = slotsLeft;
    carryMid = carryLeft;
    if (strobes.take) begin
      availMid = slotsLeft - needSlots;
      if (strobes.wide) carryMid = uopCount - WIDTH_U;
      if (strobes.closeGroup) availMid = '0;
    end
  end

  // Opening of the next cycle, draining surplus first.
  assign consumed = (carryMid >= WIDTH_U) ? WIDTH_C : CNT_W'(carryMid);

  always_comb begin
    availNext = availMid;
    carryNext = carryMid;
    spillNext = '0;
    if (strobes.newCycle) begin
      if (carryMid == '0) begin
        availNext = WIDTH_C;
      end else begin
        availNext = WIDTH_C - consumed;
        carryNext = carryMid - UOP_W'(consumed);
        spillNext = consumed;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotsLeft <= WIDTH_C;
      carryLeft <= '0;
      spillUops <= '0;
    end else begin
      slotsLeft <= availNext;
      carryLeft <= carryNext;
      spillUops <= spillNext;
    end
  end

  // R4
  fresh_cycle_full_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.newCycle && !strobes.take && carryLeft == '0) |=> (slotsLeft == WIDTH_C));

  // R9
  end_group_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.closeGroup && !strobes.newCycle) |=> (slotsLeft == '0));

  // R3
  wide_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.take && strobes.wide && !strobes.newCycle)
      |=> (carryLeft == $past(uopCount) - WIDTH_U));

  // R5
  spill_report_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.newCycle && !strobes.take && carryLeft != '0)
      |=> (spillUops == (($past(carryLeft) >= WIDTH_U) ? WIDTH_C : CNT_W'($past(carryLeft)))));

  // R2
  slots_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    slotsLeft <= WIDTH_C);

endmodule

// File: rtl/uop_dispatch_slots.sv
`timescale 1ns/1ps
module uop_dispatch_slots
  import dispatch_slot_pkg::*;
#(
  parameter int unsigned DISP_W = 4,
  parameter int unsigned UOP_W  = 4,
  parameter int unsigned ROB_W  = 6,
  localparam int unsigned CNT_W = $clog2(DISP_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [UOP_W-1:0] uopCount,
  input  logic             beginGroup,
  input  logic             endGroup,
  input  logic [ROB_W-1:0] robFree,
  input  logic             rfReady,
  input  logic             nextReady,
  input  logic             cycleBegin,
  output logic             accept,
  output logic [2:0]       stallCode,
  output logic [CNT_W-1:0] instUops,
  output logic [CNT_W-1:0] spillUops,
  output logic [CNT_W-1:0] slotsLeft,
  output logic [UOP_W-1:0] carryLeft
);

  slotStrobes_t     strobes;
  stall_e           stallEnum;
  logic [CNT_W-1:0] needSlots;

  dispatch_slot_ctrl #(.DISP_W(DISP_W), .UOP_W(UOP_W), .ROB_W(ROB_W)) ctrl_i (
    .clk(clk), .rst(rst), .instValid(instValid), .uopCount(uopCount),
    .beginGroup(beginGroup), .endGroup(endGroup), .robFree(robFree),
    .rfReady(rfReady), .nextReady(nextReady), .cycleBegin(cycleBegin),
    .slotsLeft(slotsLeft), .carryLeft(carryLeft), .accept(accept),
    .stallCode(stallEnum), .needSlots(needSlots), .strobes(strobes)
  );

  dispatch_slot_data #(.DISP_W(DISP_W), .UOP_W(UOP_W)) data_i (
    .clk(clk), .rst(rst), .strobes(strobes), .needSlots(needSlots),
    .uopCount(uopCount), .slotsLeft(slotsLeft), .carryLeft(carryLeft),
    .spillUops(spillUops), .instUops(instUops)
  );

  assign stallCode = stallEnum;

endmodule

// File: tb/uop_dispatch_slots_tb_top.sv
`timescale 1ns/1ps
module uop_dispatch_slots_tb_top;

  localparam int W     = 4;
  localparam int UOP_W = 4;
  localparam int ROB_W = 6;
  localparam int CNT_W = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0, beginGroup = 1'b0, endGroup = 1'b0;
  logic rfReady = 1'b0, nextReady = 1'b0, cycleBegin = 1'b0;
  logic [UOP_W-1:0] uopCount = '0;
  logic [ROB_W-1:0] robFree = '0;
  logic accept;
  logic [2:0] stallCode;
  logic [CNT_W-1:0] instUops, spillUops, slotsLeft;
  logic [UOP_W-1:0] carryLeft;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int availM = W;
  int carryM = 0;
  int spillM = 0;
  string slotTag = "R1";
  string carryTag = "R1";

  always #5 clk = ~clk;

  uop_dispatch_slots #(.DISP_W(W), .UOP_W(UOP_W), .ROB_W(ROB_W)) dut_i (
    .clk(clk), .rst(rst), .instValid(instValid), .uopCount(uopCount),
    .beginGroup(beginGroup), .endGroup(endGroup), .robFree(robFree),
    .rfReady(rfReady), .nextReady(nextReady), .cycleBegin(cycleBegin),
    .accept(accept), .stallCode(stallCode), .instUops(instUops),
    .spillUops(spillUops), .slotsLeft(slotsLeft), .carryLeft(carryLeft)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int u, input bit b, input bit e,
                      input int rob, input bit rf, input bit nx, input bit cb);
    int needE, codeE, cons;
    bit accE;
    string accTag;
    @(negedge clk);
    instValid = v; uopCount = UOP_W'(u); beginGroup = b; endGroup = e;
    robFree = ROB_W'(rob); rfReady = rf; nextReady = nx; cycleBegin = cb;
    #2;
    needE = (u < W) ? u : W;
    codeE = 0;
    accTag = "R2";
    if (v) begin
      if (carryM != 0)                  begin codeE = 1; accTag = "R6"; end
      else if (availM == 0)             begin codeE = 1; accTag = "R7"; end
      else if (b && availM != W)        begin codeE = 1; accTag = "R8"; end
      else if (needE > availM)          begin codeE = 1; accTag = (u > W) ? "R3" : "R2"; end
      else if (rob < u)                 begin codeE = 2; accTag = "R10"; end
      else if (!rf)                     begin codeE = 3; accTag = "R10"; end
      else if (!nx)                     begin codeE = 4; accTag = "R10"; end
    end
    accE = v && (codeE == 0);
    check(slotTag, "slotsLeft", int'(slotsLeft), availM);
    check(carryTag, "carryLeft", int'(carryLeft), carryM);
    check("R5", "spillUops", int'(spillUops), spillM);
    check(accTag, "accept", int'(accept), int'(accE));
    check("R11", "stallCode", int'(stallCode), codeE);
    check("R12", "instUops", int'(instUops), accE ? needE : 0);
    // model of the clock edge
    slotTag = "R2";
    carryTag = "R6";
    if (accE) begin
      availM -= needE;
      if (u > W) begin carryM = u - W; slotTag = "R3"; carryTag = "R3"; end
      if (e) begin availM = 0; slotTag = "R9"; end
    end
    spillM = 0;
    if (cb) begin
      if (carryM == 0) begin
        availM = W; slotTag = "R4";
      end else begin
        cons = (carryM >= W) ? W : carryM;
        availM = W - cons;
        carryM -= cons;
        spillM = cons;
        slotTag = "R5"; carryTag = "R5";
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    check("R1", "slotsLeft after reset", int'(slotsLeft), W);
    check("R1", "carryLeft after reset", int'(carryLeft), 0);
    check("R1", "spillUops after reset", int'(spillUops), 0);
    check("R11", "stallCode idle", int'(stallCode), 0);

    for (int pre = 0; pre <= W + 1; pre++) begin
      for (int u = 1; u <= 2 * W + 1; u++) begin
        for (int flags = 0; flags < 4; flags++) begin
          for (int rdy = 0; rdy < 8; rdy++) begin
            // prefix: bring slotsLeft to a chosen level within this cycle
            if (pre >= 1 && pre <= W)
              step(1'b1, pre, 1'b0, 1'b0, 63, 1'b1, 1'b1, 1'b0);
            else if (pre == W + 1)
              step(1'b1, 1, 1'b0, 1'b1, 63, 1'b1, 1'b1, 1'b0);
            // instruction under test
            step(1'b1, u, flags[0], flags[1], rdy[0] ? u : u - 1,
                 rdy[1], rdy[2], rdy[0] ^ rdy[1]);
            // drain surplus and open a fresh cycle
            for (int d = 0; d < 3; d++)
              step(1'b0, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1);
          end
        end
      end
    end

    // R5/R6: widest instruction drained across several cycles while others wait
    step(1'b1, 2 * W + 1, 1'b0, 1'b0, 63, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1, 1'b0, 1'b0, 63, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1, 1'b0, 1'b0, 63, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule